// File: doc/BRIEF.md
# Bit Counting Unit with Word Mode

This combinational unit gives one of three counts for a 64-bit operand: leading zeros, trailing zeros or the number of set bits. A 2-bit function select picks the count. A word-mode flag limits every count to the low 32 bits of the operand. The count comes out zero-extended to the full data width. The largest possible value is the operand width, so only the low seven result bits can be nonzero.

An execute stage of a 64-bit integer datapath uses it, with decode and register access left to the surrounding pipeline. There is no clock and no state. The result depends only on the present inputs.

Top module: `bitcnt_unit`

## Requirements
- R1: With func_i = 2'b00 and word_i = 0, count_o is the number of zero bits above the highest set bit of opnd_i; an all-zero operand gives 64.
- R2: With func_i = 2'b01 and word_i = 0, count_o is the number of zero bits below the lowest set bit of opnd_i; an all-zero operand gives 64.
- R3: With func_i = 2'b10 and word_i = 0, count_o is the number of set bits in opnd_i (0 to 64).
- R4: With func_i = 2'b00 and word_i = 1, count_o is the leading-zero count of opnd_i[31:0] taken as a 32-bit value (32 when that half is zero), and opnd_i[63:32] has no effect.
- R5: With func_i = 2'b01 and word_i = 1, count_o is the trailing-zero count of opnd_i[31:0] (32 when that half is zero), and opnd_i[63:32] has no effect.
- R6: With func_i = 2'b10 and word_i = 1, count_o is the number of set bits in opnd_i[31:0], and opnd_i[63:32] has no effect.
- R7: With func_i = 2'b11, count_o is zero for any operand and either mode.
- R8: count_o[63:7] is zero at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 64 | Operand to count |
| func_i | input | 2 | Count select: 00 leading zeros, 01 trailing zeros, 10 set bits, 11 none |
| word_i | input | 1 | Restricts the count to the low 32 bits when 1 |
| count_o | output | 64 | Count, zero-extended |

## Verification
The unit holds no state, so any fault appears at count_o for the same input vector that triggers it. A wrong word-mode mask or a wrong offset shows up as a count that moves when only the upper half of the operand changes, or as a zero low half that does not give 32. A fault in the leading or trailing priority logic shows up as an off-by-one count on single-set-bit operands at a particular bit position. For that reason every bit position is driven in both modes.

// File: rtl/bitcnt_pkg.sv
package bitcnt_pkg;

   localparam int unsigned DATA_W_DEF = 64;
   localparam int unsigned WORD_W_DEF = 32;
   localparam int unsigned GRP_W_DEF  = 8;

   typedef enum logic [1:0] {
      CNT_LEAD  = 2'b00,
      CNT_TRAIL = 2'b01,
      CNT_POP   = 2'b10,
      CNT_NONE  = 2'b11
   } cnt_func_e;

endpackage

// File: rtl/bitcnt_lead.sv
// Leading-zero counter: returns W for an all-zero input.
module bitcnt_lead #(
   parameter int unsigned W     = 64,
   parameter int unsigned CNT_W = $clog2(W + 1)
) (
   input  logic [W-1:0]     data_i,
   output logic [CNT_W-1:0] cnt_o
);

   generate
      if (CNT_W < $clog2(W + 1)) begin : g_bad_width
         $error("bitcnt_lead: CNT_W too narrow for W");
      end
   endgenerate

   logic found;

   always_comb begin
      cnt_o = CNT_W'(W);
      found = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         if (!found && data_i[i]) begin
            cnt_o = CNT_W'(W - 1 - i);
            found = 1'b1;
         end
      end
   end

   always_comb begin
      if (!$isunknown(data_i)) begin
         AST_LEAD_RANGE: assert (cnt_o <= CNT_W'(W))
            else $error("leading count above width"); // R1
         AST_LEAD_ZERO: assert ((data_i == '0) == (cnt_o == CNT_W'(W)))
            else $error("leading count width mismatch for zero"); // R1
      end
   end

endmodule

// File: rtl/bitcnt_trail.sv
// Trailing-zero counter built from a reversed leading-zero counter.
module bitcnt_trail #(
   parameter int unsigned W     = 64,
   parameter int unsigned CNT_W = $clog2(W + 1)
) (
   input  logic [W-1:0]     data_i,
   output logic [CNT_W-1:0] cnt_o
);

   logic [W-1:0] rev;

   generate
      for (genvar b = 0; b < W; b++) begin : g_rev
         assign rev[b] = data_i[W - 1 - b];
      end
   endgenerate

   bitcnt_lead #(.W(W), .CNT_W(CNT_W)) u_lead (
      .data_i (rev),
      .cnt_o  (cnt_o)
   );

   always_comb begin
      if (!$isunknown(data_i) && data_i[0]) begin
         AST_TRAIL_BIT0: assert (cnt_o == '0)
            else $error("trailing count nonzero with bit 0 set"); // R2
      end
   end

endmodule

// File: rtl/bitcnt_pop.sv
// Population counter: per-group sums followed by a total.
module bitcnt_pop #(
   parameter int unsigned W     = 64,
   parameter int unsigned GRP_W = 8,
   parameter int unsigned CNT_W = $clog2(W + 1)
) (
   input  logic [W-1:0]     data_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam int unsigned NGRP  = W / GRP_W;
   localparam int unsigned GSUM_W = $clog2(GRP_W + 1);

   generate
      if ((W % GRP_W) != 0) begin : g_bad_grp
         $error("bitcnt_pop: W must be a multiple of GRP_W");
      end
   endgenerate

   logic [GSUM_W-1:0] gsum [NGRP];

   generate
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         always_comb begin
            gsum[g] = '0;
            for (int k = 0; k < GRP_W; k++) begin
               gsum[g] = gsum[g] + GSUM_W'(data_i[g*GRP_W + k]);
            end
         end
      end
   endgenerate

   always_comb begin
      cnt_o = '0;
      for (int g = 0; g < NGRP; g++) begin
         cnt_o = cnt_o + CNT_W'(gsum[g]);
      end
   end

   always_comb begin
      if (!$isunknown(data_i)) begin
         AST_POP_RANGE: assert (cnt_o <= CNT_W'(W))
            else $error("population count above width"); // R3
         AST_POP_ONES: assert ((data_i == '1) == (cnt_o == CNT_W'(W)))
            else $error("population count of all ones wrong"); // R3
      end
   end

endmodule

// File: rtl/bitcnt_unit.sv
module bitcnt_unit
   import bitcnt_pkg::*;
#(
   parameter int unsigned DATA_W = DATA_W_DEF,
   parameter int unsigned WORD_W = WORD_W_DEF,
   parameter int unsigned GRP_W  = GRP_W_DEF
) (
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [1:0]        func_i,
   input  logic              word_i,
   output logic [DATA_W-1:0] count_o
);

   localparam int unsigned CNT_W = $clog2(DATA_W + 1);
   localparam int unsigned UPR_W = DATA_W - WORD_W;

   generate
      if (WORD_W >= DATA_W || WORD_W == 0) begin : g_bad_word
         $error("bitcnt_unit: WORD_W must be in 1..DATA_W-1");
      end
   endgenerate

   logic [DATA_W-1:0] zext_opnd;   // upper part cleared in word mode
   logic [DATA_W-1:0] oext_opnd;   // upper part forced to ones in word mode
   logic [CNT_W-1:0]  lead_raw, trail_raw, pop_raw, lead_adj, sel_cnt;

   assign zext_opnd = word_i ? {{UPR_W{1'b0}}, opnd_i[WORD_W-1:0]} : opnd_i;
   assign oext_opnd = word_i ? {{UPR_W{1'b1}}, opnd_i[WORD_W-1:0]} : opnd_i;

   bitcnt_lead #(.W(DATA_W), .CNT_W(CNT_W)) u_lead (
      .data_i (zext_opnd),
      .cnt_o  (lead_raw)
   );

   bitcnt_trail #(.W(DATA_W), .CNT_W(CNT_W)) u_trail (
      .data_i (oext_opnd),
      .cnt_o  (trail_raw)
   );

   bitcnt_pop #(.W(DATA_W), .GRP_W(GRP_W), .CNT_W(CNT_W)) u_pop (
      .data_i (zext_opnd),
      .cnt_o  (pop_raw)
   );

   assign lead_adj = word_i ? (lead_raw - CNT_W'(UPR_W)) : lead_raw;

   always_comb begin
      case (cnt_func_e'(func_i))
         CNT_LEAD:  sel_cnt = lead_adj;
         CNT_TRAIL: sel_cnt = trail_raw;
         CNT_POP:   sel_cnt = pop_raw;
         default:   sel_cnt = '0;
      endcase
   end

   assign count_o = {{(DATA_W - CNT_W){1'b0}}, sel_cnt};

   always_comb begin
      if (!$isunknown({opnd_i, func_i, word_i})) begin
         AST_UPPER_CLEAR: assert (count_o[DATA_W-1:CNT_W] == '0)
            else $error("result upper bits set"); // R8
         AST_ZERO_AGREE: assert ((pop_raw == '0) == (lead_raw == CNT_W'(DATA_W)))
            else $error("zero detection disagrees between counters"); // R1
         AST_WORD_LEAD_FLOOR: assert (!word_i || lead_raw >= CNT_W'(UPR_W))
            else $error("word-mode leading count below upper width"); // R4
         AST_WORD_TRAIL_CAP: assert (!word_i || trail_raw <= CNT_W'(WORD_W))
            else $error("word-mode trailing count above word width"); // R5
         AST_WORD_POP_CAP: assert (!word_i || pop_raw <= CNT_W'(WORD_W))
            else $error("word-mode population above word width"); // R6
      end
   end

endmodule

// File: tb/bitcnt_unit_tb.sv
module bitcnt_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] opnd = '0;
   logic [1:0]  func = 2'b00;
   logic        word = 1'b0;
   logic [63:0] count;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   bitcnt_unit u_dut (
      .opnd_i  (opnd),
      .func_i  (func),
      .word_i  (word),
      .count_o (count)
   );

   function automatic int ref_count(logic [63:0] v, logic [1:0] f, logic w);
      int n = w ? 32 : 64;
      int c = 0;
      case (f)
         2'b00: begin
            for (int i = n - 1; i >= 0; i--) begin
               if (v[i]) break;
               c++;
            end
         end
         2'b01: begin
            for (int i = 0; i < n; i++) begin
               if (v[i]) break;
               c++;
            end
         end
         2'b10: begin
            for (int i = 0; i < n; i++) c += int'(v[i]);
         end
         default: c = 0;
      endcase
      return c;
   endfunction

   function automatic string req_tag(logic [1:0] f, logic w);
      case (f)
         2'b00:   return w ? "R4" : "R1";
         2'b01:   return w ? "R5" : "R2";
         2'b10:   return w ? "R6" : "R3";
         default: return "R7";
      endcase
   endfunction

   task automatic apply(logic [63:0] v, logic [1:0] f, logic w);
      logic [63:0] exp;
      @(posedge clk);
      opnd = v; func = f; word = w;
      @(negedge clk);
      exp = 64'(ref_count(v, f, w));
      n_chk++;
      if (count !== exp) begin
         n_bad++;
         $display("FAIL %s op=%h func=%b word=%b actual=%0d expected=%0d",
                  req_tag(f, w), v, f, w, count, exp);
      end
      n_chk++;
      if (count[63:7] !== '0) begin
         n_bad++;
         $display("FAIL R8 upper bits actual=%h expected=0", count[63:7]);
      end
   endtask

   task automatic all_funcs(logic [63:0] v);
      for (int f = 0; f < 4; f++) begin
         apply(v, 2'(f), 1'b0);
         apply(v, 2'(f), 1'b1);
      end
   endtask

   // upper half must not matter in word mode (R4, R5, R6)
   task automatic upper_ignored(logic [31:0] lo);
      for (int f = 0; f < 3; f++) begin
         apply({32'h0000_0000, lo}, 2'(f), 1'b1);
         apply({32'hFFFF_FFFF, lo}, 2'(f), 1'b1);
         apply({32'h8000_0001, lo}, 2'(f), 1'b1);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // initial state: zero operand, leading count, full mode -> 64 (R1)
      @(negedge clk);
      n_chk++;
      if (count !== 64'd64) begin
         n_bad++;
         $display("FAIL R1 initial actual=%0d expected=64", count);
      end
      all_funcs(64'h0);                     // zero: 64 / 32 (R1 R2 R4 R5)
      all_funcs(64'hFFFF_FFFF_FFFF_FFFF);   // all ones (R3 R6)
      all_funcs(64'hFFFF_FFFF_0000_0000);   // only upper half set
      all_funcs(64'h0000_0000_FFFF_FFFF);
      for (int b = 0; b < 64; b++) all_funcs(64'h1 << b);
      for (int b = 0; b < 64; b++) all_funcs(~(64'h1 << b));
      upper_ignored(32'h0);
      upper_ignored(32'h0001_0000);
      upper_ignored(32'h8000_0000);
      upper_ignored(32'h0000_0001);
      for (int r = 0; r < 300; r++) begin
         logic [63:0] v;
         v = {$urandom(), $urandom()};
         all_funcs(v);
         all_funcs(v & 64'h00F0_0000_0F00_0000);
      end
      // func 11 always zero (R7)
      apply(64'hDEAD_BEEF_0000_0000, 2'b11, 1'b0);
      apply(64'h0, 2'b11, 1'b1);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule